// File: doc/BRIEF.md
# RSA Key Parameter Generator

This block derives the public numbers of an RSA key pair from two 32-bit prime candidates and a 64-bit candidate public exponent. It computes the public modulus as the product of the two primes. It computes the totient as the product of each prime decreased by one. It then reduces the exponent modulo the totient. A result equal to one of the small values that are coprime to the totient tells the caller that the exponent choice is plausible. Prime testing and any full coprimality test are left to the caller.

Both products come from one shared sequential multiplier. The multiplier uses radix-2 Booth recoding and examines one bit pair per clock. Each operand is widened with a zero bit, so the operands are treated as unsigned. The two multiplications run one after the other. A restoring shift-and-subtract unit then produces the remainder over 64 iterations.

The block is controlled by plain pins. A one-cycle `start` pulse in the idle state latches all inputs. `busy` then stays high until the cycle in which `done` pulses. The block has no back-pressure: the results are registered and stay on the outputs until the next accepted start, so the caller may read them at any time. A `start` that arrives while the block is busy is dropped.

Top module: `rsa_keyparam_gen`

## Requirements
- R1: After reset `busy`, `done` and `tot_zero_err` are low and `modulus`, `totient` and `exp_mod` are zero.
- R2: `modulus` equals the full 64-bit unsigned product of `prime_a` and `prime_b`, including operands whose top bit is set (13 and 17 give 221).
- R3: `totient` equals the 64-bit unsigned product of (`prime_a` - 1) and (`prime_b` - 1), each difference taken modulo 2^32 (13 and 17 give 192).
- R4: When the totient is nonzero, `exp_mod` equals `exp_in` modulo the totient (17 mod 192 gives 17), and it is always smaller than the totient.
- R5: `done` is high for exactly one cycle per accepted start. In that cycle `busy` is low, and `busy` falls only together with `done`.
- R6: An accepted start clears `modulus`, `totient`, `exp_mod` and `tot_zero_err` to zero in the following cycle. After `done`, the outputs hold their values until the next accepted start, whatever the inputs do.
- R7: When the totient is zero (either prime input equals 1), `tot_zero_err` is high and `exp_mod` is zero, and `modulus` still holds the product. The next accepted start clears the flag.
- R8: A `start` pulse received while `busy` is high is ignored: the running job completes with its original inputs and on its original schedule.
- R9: With the default widths, each multiplication takes 33 Booth steps. `done` rises 136 clock edges after the edge that accepts `start` when the totient is nonzero, and 70 edges after it when the totient is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| prime_a | input | 32 | First prime candidate |
| prime_b | input | 32 | Second prime candidate |
| exp_in | input | 64 | Candidate public exponent |
| busy | output | 1 | High from the cycle after an accepted start until done |
| done | output | 1 | One-cycle pulse: all results valid |
| modulus | output | 64 | prime_a × prime_b |
| totient | output | 64 | (prime_a − 1) × (prime_b − 1) |
| exp_mod | output | 64 | exp_in mod totient, or zero on error |
| tot_zero_err | output | 1 | Totient was zero |

## Verification
A corrupted Booth step, such as a wrong add or subtract choice or a lost sign bit in the shift, gives a wrong `modulus` at the first `done`. Operands with the top bit set expose this most readily. A wrong operand selection for the second product, or a wrong subtract in the remainder unit, first shows as a wrong `totient` or `exp_mod` at that same `done`. A wrong step count or sequencer transition shifts `done` away from its fixed edge count, and the bench sees this at the first job. A sequencer that reacts to a start while busy changes the results or the timing of the job that is already running.

// File: rtl/rkg_pkg.sv
package rkg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL_N = 2'd1,
    ST_MUL_T = 2'd2,
    ST_RED   = 2'd3
  } rkg_state_e;
endpackage

// File: rtl/booth_mul_seq.sv
// Sequential radix-2 Booth multiplier for unsigned operands.
// Each operand is widened by one zero bit so that it reads as a positive
// two's-complement value; one recoded bit pair is consumed per clock.
module booth_mul_seq #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int OW = W + 1;              // widened multiplier length = step count
  localparam int AW = W + 2;              // accumulator with headroom for +/- M
  localparam int CW = $clog2(OW + 1);

  logic [AW-1:0] acc;
  logic [OW-1:0] mq;
  logic          q_prev;
  logic [AW-1:0] mcand;
  logic [CW-1:0] steps_left;
  logic          done_r;
  logic [AW-1:0] acc_next;

  always_comb begin
    unique case ({mq[0], q_prev})
      2'b01:   acc_next = acc + mcand;
      2'b10:   acc_next = acc - mcand;
      default: acc_next = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      mq         <= '0;
      q_prev     <= 1'b0;
      mcand      <= '0;
      steps_left <= '0;
      done_r     <= 1'b0;
    end else if (go) begin
      acc        <= '0;
      mq         <= {1'b0, op_b};
      q_prev     <= 1'b0;
      mcand      <= {2'b00, op_a};
      steps_left <= CW'(OW);
      done_r     <= 1'b0;
    end else if (steps_left != '0) begin
      acc        <= {acc_next[AW-1], acc_next[AW-1:1]};
      mq         <= {acc_next[0], mq[OW-1:1]};
      q_prev     <= mq[0];
      steps_left <= steps_left - CW'(1);
      done_r     <= (steps_left == CW'(1));
    end else begin
      done_r     <= 1'b0;
    end
  end

  // The product is nonnegative and below 2^(2W); its low 2W bits are exact.
  assign product = {acc[W-2:0], mq};
  assign done    = done_r;
endmodule

// File: rtl/mod_reduce_seq.sv
// Restoring shift-and-subtract reducer: remainder of dividend / divisor.
// One dividend bit per clock; the divisor must be nonzero.
module mod_reduce_seq #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_r;
  logic [W-1:0]  shift_r;
  logic [W-1:0]  div_r;
  logic [CW-1:0] bits_left;
  logic          done_r;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_next;

  always_comb begin
    trial    = {rem_r, shift_r[W-1]};
    fits     = (trial >= {1'b0, div_r});
    rem_next = fits ? (trial[W-1:0] - div_r) : trial[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r     <= '0;
      shift_r   <= '0;
      div_r     <= '0;
      bits_left <= '0;
      done_r    <= 1'b0;
    end else if (go) begin
      rem_r     <= '0;
      shift_r   <= dividend;
      div_r     <= divisor;
      bits_left <= CW'(W);
      done_r    <= 1'b0;
    end else if (bits_left != '0) begin
      rem_r     <= rem_next;
      shift_r   <= {shift_r[W-2:0], 1'b0};
      bits_left <= bits_left - CW'(1);
      done_r    <= (bits_left == CW'(1));
    end else begin
      done_r    <= 1'b0;
    end
  end

  assign remainder = rem_r;
  assign done      = done_r;
endmodule

// File: rtl/rsa_keyparam_gen.sv
module rsa_keyparam_gen #(
  parameter int PW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PW-1:0]   prime_a,
  input  logic [PW-1:0]   prime_b,
  input  logic [2*PW-1:0] exp_in,
  output logic            busy,
  output logic            done,
  output logic [2*PW-1:0] modulus,
  output logic [2*PW-1:0] totient,
  output logic [2*PW-1:0] exp_mod,
  output logic            tot_zero_err
);
  import rkg_pkg::*;
  localparam int KW = 2 * PW;

  rkg_state_e    state;
  logic [PW-1:0] pa_r, pb_r;
  logic [KW-1:0] exp_r;
  logic          mul_go, red_go, done_r, err_r;
  logic [KW-1:0] modulus_r, totient_r, expmod_r;
  logic [PW-1:0] mul_a, mul_b;
  logic          mul_done, red_done;
  logic [KW-1:0] mul_prod, red_rem;

  // Operand select: the go pulse is sampled while the sequencer already
  // sits in the state of the product it requests.
  always_comb begin
    if (state == ST_MUL_T) begin
      mul_a = pa_r - PW'(1);
      mul_b = pb_r - PW'(1);
    end else begin
      mul_a = pa_r;
      mul_b = pb_r;
    end
  end

  booth_mul_seq #(.W(PW)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (mul_go),
    .op_a    (mul_a),
    .op_b    (mul_b),
    .done    (mul_done),
    .product (mul_prod)
  );

  mod_reduce_seq #(.W(KW)) u_red (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (red_go),
    .dividend  (exp_r),
    .divisor   (totient_r),
    .done      (red_done),
    .remainder (red_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pa_r      <= '0;
      pb_r      <= '0;
      exp_r     <= '0;
      mul_go    <= 1'b0;
      red_go    <= 1'b0;
      done_r    <= 1'b0;
      err_r     <= 1'b0;
      modulus_r <= '0;
      totient_r <= '0;
      expmod_r  <= '0;
    end else begin
      mul_go <= 1'b0;
      red_go <= 1'b0;
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pa_r      <= prime_a;
            pb_r      <= prime_b;
            exp_r     <= exp_in;
            modulus_r <= '0;
            totient_r <= '0;
            expmod_r  <= '0;
            err_r     <= 1'b0;
            mul_go    <= 1'b1;
            state     <= ST_MUL_N;
          end
        end
        ST_MUL_N: begin
          if (mul_done) begin
            modulus_r <= mul_prod;
            mul_go    <= 1'b1;
            state     <= ST_MUL_T;
          end
        end
        ST_MUL_T: begin
          if (mul_done) begin
            totient_r <= mul_prod;
            if (mul_prod == '0) begin
              err_r    <= 1'b1;
              expmod_r <= '0;
              done_r   <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              red_go <= 1'b1;
              state  <= ST_RED;
            end
          end
        end
        ST_RED: begin
          if (red_done) begin
            expmod_r <= red_rem;
            done_r   <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = done_r;
  assign modulus      = modulus_r;
  assign totient      = totient_r;
  assign exp_mod      = expmod_r;
  assign tot_zero_err = err_r;
endmodule

// File: rtl/rkg_checker.sv
module rkg_checker #(
  parameter int KW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [KW-1:0] modulus,
  input logic [KW-1:0] totient,
  input logic [KW-1:0] exp_mod,
  input logic          tot_zero_err
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_rem_below_totient: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tot_zero_err) |-> (exp_mod < totient));

  a_r7_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    tot_zero_err |-> (exp_mod == '0 && totient == '0));

  a_r6_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (modulus == '0 && totient == '0 && exp_mod == '0 && !tot_zero_err && busy));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(modulus) && $stable(totient) && $stable(exp_mod) && $stable(tot_zero_err)));
endmodule

bind rsa_keyparam_gen rkg_checker #(.KW(2*PW)) u_rkg_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .modulus      (modulus),
  .totient      (totient),
  .exp_mod      (exp_mod),
  .tot_zero_err (tot_zero_err)
);

// File: tb/rsa_keyparam_gen_bench.sv
`timescale 1ns/1ps
module rsa_keyparam_gen_bench;
  localparam int LAT_OK  = 136;
  localparam int LAT_ERR = 70;

  typedef struct packed {
    logic [31:0] pa;
    logic [31:0] pb;
    logic [63:0] ex;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'd13,         32'd17,         64'd17},
    '{32'hFFFF_FFFF,  32'hFFFF_FFFF,  64'hFFFF_FFFF_FFFF_FFFF},
    '{32'hFFFF_FFFB,  32'h8000_0001,  64'h1234_5678_9ABC_DEF0},
    '{32'd2,          32'd3,          64'd5},
    '{32'd3,          32'd5,          64'd8},
    '{32'd65537,      32'd65539,      64'd1000003},
    '{32'd0,          32'd7,          64'd100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] prime_a = '0;
  logic [31:0] prime_b = '0;
  logic [63:0] exp_in = '0;
  logic        busy, done, tot_zero_err;
  logic [63:0] modulus, totient, exp_mod;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rsa_keyparam_gen u_rsa_keyparam_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .prime_a(prime_a), .prime_b(prime_b), .exp_in(exp_in),
    .busy(busy), .done(done), .modulus(modulus), .totient(totient),
    .exp_mod(exp_mod), .tot_zero_err(tot_zero_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mod(input logic [31:0] a, input logic [31:0] b);
    return {32'd0, a} * {32'd0, b};
  endfunction

  function automatic logic [63:0] ref_tot(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] am = a - 32'd1;
    logic [31:0] bm = b - 32'd1;
    return {32'd0, am} * {32'd0, bm};
  endfunction

  // Drives one start pulse, accepted at the next rising edge.
  task automatic pulse_start(input logic [31:0] a, input logic [31:0] b, input logic [63:0] e);
    @(negedge clk);
    prime_a = a; prime_b = b; exp_in = e; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  // Counts rising edges after the accepting edge until done is seen.
  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!done && lat < 1000);
  endtask

  task automatic run_and_check(input logic [31:0] a, input logic [31:0] b,
                               input logic [63:0] e, input string tag);
    int lat;
    logic [63:0] em, et, ee;
    em = ref_mod(a, b);
    et = ref_tot(a, b);
    ee = (et == 0) ? 64'd0 : (e % et);
    pulse_start(a, b, e);
    wait_done(lat);
    chk("R9", {tag, " latency"}, 64'(lat), (et == 0) ? 64'(LAT_ERR) : 64'(LAT_OK));
    chk("R2", {tag, " modulus"}, modulus, em);
    chk("R3", {tag, " totient"}, totient, et);
    chk("R4", {tag, " exp_mod"}, exp_mod, ee);
    chk("R7", {tag, " error flag"}, 64'(tot_zero_err), 64'(et == 0));
    chk("R5", {tag, " busy low with done"}, 64'(busy), 64'd0);
    @(posedge clk); #1;
    chk("R5", {tag, " done single cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [63:0] m0, t0, e0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 64'(busy), 0);
    chk("R1", "done", 64'(done), 0);
    chk("R1", "err", 64'(tot_zero_err), 0);
    chk("R1", "modulus", modulus, 0);
    chk("R1", "totient", totient, 0);
    chk("R1", "exp_mod", exp_mod, 0);

    // Explicit worked values: R2 221, R3 192, R4 17
    pulse_start(32'd13, 32'd17, 64'd17);
    wait_done(lat);
    chk("R2", "13*17", modulus, 64'd221);
    chk("R3", "12*16", totient, 64'd192);
    chk("R4", "17 mod 192", exp_mod, 64'd17);

    foreach (VECS[i]) begin
      run_and_check(VECS[i].pa, VECS[i].pb, VECS[i].ex, $sformatf("vec%0d", i));
    end

    // R7 zero totient, from either side, then cleared by a good job
    run_and_check(32'd1, 32'd19, 64'd55, "err_a1");
    chk("R7", "modulus kept on error", modulus, 64'd19);
    run_and_check(32'd23, 32'd1, 64'd9, "err_b1");
    chk("R7", "flag set before next", 64'(tot_zero_err), 1);
    run_and_check(32'd11, 32'd7, 64'd61, "after_err");
    chk("R7", "flag cleared by new start", 64'(tot_zero_err), 0);

    // R6 hold: inputs move without start, outputs stay
    m0 = modulus; t0 = totient; e0 = exp_mod;
    @(negedge clk);
    prime_a = 32'd99; prime_b = 32'd101; exp_in = 64'd7;
    repeat (20) @(negedge clk);
    chk("R6", "modulus held", modulus, m0);
    chk("R6", "totient held", totient, t0);
    chk("R6", "exp_mod held", exp_mod, e0);

    // R6 clear on accepted start
    pulse_start(32'd13, 32'd17, 64'd17);
    chk("R6", "modulus cleared", modulus, 0);
    chk("R6", "exp_mod cleared", exp_mod, 0);
    chk("R5", "busy after start", 64'(busy), 1);
    // R8 start while busy is ignored
    repeat (10) @(posedge clk);
    @(negedge clk);
    prime_a = 32'd3; prime_b = 32'd5; exp_in = 64'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 11;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!done && lat < 1000);
    chk("R8", "latency unchanged", 64'(lat), 64'(LAT_OK));
    chk("R8", "modulus from first job", modulus, 64'd221);
    chk("R8", "totient from first job", totient, 64'd192);
    chk("R8", "exp_mod from first job", exp_mod, 64'd17);
    repeat (5) @(posedge clk); #1;
    chk("R8", "no second job started", 64'(busy), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule